// File: doc/BRIEF.md
# UART Status Flag Controller

This block keeps the four status flags of a UART peripheral: transmit buffer empty, transmission complete, receive buffer full and receive overrun. It sits between the register decode of the peripheral and its serial shifters. The decode supplies one-cycle strobes for a status-register read, a data-register read and a data-register write, together with the transmit-enable level and a send-break write strobe. The shifters report when the buffered transmit byte moves into the transmit shifter, whether the transmitter is still shifting anything out, and when a received character is ready to move into the receive buffer.

No flag can be cleared by a single access. Software first reads the status register while the flag is 1, which arms that flag. A later access of the kind that belongs to that flag then clears it. The arm is kept per flag, so other register accesses in between do not disturb it. Transmission complete accepts three different clearing actions. The block also produces the load enable for the receive data register, so a character that arrives while the buffer is still full is dropped and the buffer keeps its old contents.

All ports are plain control and status pins. No data moves through this block, so it has no valid/ready interface and no back-pressure. Flags are registered and change on the clock edge after the event that causes them. The receive load enable is combinational and is valid in the same cycle as `rx_ready`.

Top module: `uart_flag_ctrl`

## Requirements
- R1: After reset, `tx_empty` and `tx_done` read 1, and `rx_full` and `rx_overrun` read 0.
- R2: A `tx_load` pulse makes `tx_empty` 1 on the next cycle.
- R3: `tx_empty` clears on the cycle after a `data_wr` pulse only if an earlier `stat_rd` saw `tx_empty` at 1. A `data_wr` without such a read has no effect on it.
- R4: `tx_done` becomes 1 on the cycle after the idle condition (`tx_empty` = 1 and `tx_busy` = 0) goes from false to true.
- R5: After a `stat_rd` that saw `tx_done` at 1, each of these clears `tx_done` on the next cycle: a `data_wr` pulse, `tx_en` changing from 0 to 1, or a `brk_wr` pulse. Without that read, none of the three clears it.
- R6: A `rx_ready` pulse while `rx_full` is 0 drives `rx_load_en` high in the same cycle and makes `rx_full` 1 on the next cycle.
- R7: `rx_full` clears on the cycle after a `data_rd` pulse that follows a `stat_rd` which saw `rx_full` at 1. A `data_rd` without that read leaves it set.
- R8: A `rx_ready` pulse while `rx_full` is 1 keeps `rx_load_en` low and makes `rx_overrun` 1 on the next cycle, and `rx_full` stays 1.
- R9: `rx_overrun` clears through the same sequence as R7: a `stat_rd` that saw it at 1, then a `data_rd`.
- R10: Register accesses between the arming read and the clearing access do not cancel the arm. A flag that sets again after its arm has been used is not cleared by a later access unless it is read again first.
- R11: When a set event and an armed clearing access for the same flag fall in one cycle, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Data register read strobe |
| data_wr | input | 1 | Data register write strobe |
| tx_en | input | 1 | Transmit enable level |
| brk_wr | input | 1 | Strobe for writing 1 to the send-break control |
| tx_load | input | 1 | Buffered transmit byte moved into the shifter |
| tx_busy | input | 1 | Transmit shifter is sending data, a preamble or a break |
| rx_ready | input | 1 | Receive shifter holds a complete character |
| tx_empty | output | 1 | Transmit buffer empty flag |
| tx_done | output | 1 | Transmission complete flag |
| rx_full | output | 1 | Receive buffer full flag |
| rx_overrun | output | 1 | Receive overrun flag |
| rx_load_en | output | 1 | Load enable for the receive data register |

## Verification
Each flag is driven three ways: with the clearing access alone, with the arming read first, and with unrelated accesses placed between the two. This separates a flag that clears without being armed from one whose arm is lost or never taken. Transmission complete is cleared in turn by a data write, a transmit-enable rise and a break write, so each path is tested on its own. Receive characters are sent both into an empty buffer and into a full one, and one set event is made to coincide with an armed clear. Together these separate loading from overrun and check that a set in the same cycle wins over a clear.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;
  // register-side access strobes for one cycle
  typedef struct packed {
    logic stat_rd;
    logic data_rd;
    logic data_wr;
  } reg_acc_t;

  // reset values of the four flags
  localparam logic TX_EMPTY_RST = 1'b1;
  localparam logic TX_DONE_RST  = 1'b1;
  localparam logic RX_FULL_RST  = 1'b0;
  localparam logic RX_OVR_RST   = 1'b0;
endpackage

// File: rtl/flag_two_step.sv
module flag_two_step #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stat_rd,
  input  logic set_evt,
  input  logic clr_acc,
  output logic flag
);
  logic armed;
  logic clr_fire;

  assign clr_fire = armed & clr_acc & ~set_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= RST_VAL;
      armed <= 1'b0;
    end else begin
      if (set_evt)
        flag <= 1'b1;
      else if (clr_fire)
        flag <= 1'b0;

      if (set_evt || clr_fire)
        armed <= 1'b0;
      else if (stat_rd && flag)
        armed <= 1'b1;
    end
  end

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag);

  // R3
  armed_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && clr_acc && !set_evt) |=> !flag);

  // R10
  unarmed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !armed) |=> flag);
endmodule

// File: rtl/tx_flag_unit.sv
module tx_flag_unit
  import uart_flag_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  reg_acc_t acc,
  input  logic     tx_en,
  input  logic     brk_wr,
  input  logic     tx_load,
  input  logic     tx_busy,
  output logic     tx_empty,
  output logic     tx_done
);
  logic tx_en_q;
  logic idle_q;
  logic idle_now;
  logic done_set;
  logic done_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en_q <= 1'b0;
      idle_q  <= 1'b1;
    end else begin
      tx_en_q <= tx_en;
      idle_q  <= idle_now;
    end
  end

  assign idle_now = tx_empty & ~tx_busy;
  assign done_set = idle_now & ~idle_q;
  assign done_clr = acc.data_wr | (tx_en & ~tx_en_q) | brk_wr;

  flag_two_step #(.RST_VAL(TX_EMPTY_RST)) empty_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .stat_rd (acc.stat_rd),
    .set_evt (tx_load),
    .clr_acc (acc.data_wr),
    .flag    (tx_empty)
  );

  flag_two_step #(.RST_VAL(TX_DONE_RST)) done_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .stat_rd (acc.stat_rd),
    .set_evt (done_set),
    .clr_acc (done_clr),
    .flag    (tx_done)
  );

  // R2
  load_sets_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> tx_empty);

  // R4
  done_needs_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> $past(tx_empty));
endmodule

// File: rtl/rx_flag_unit.sv
module rx_flag_unit
  import uart_flag_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  reg_acc_t acc,
  input  logic     rx_ready,
  output logic     rx_full,
  output logic     rx_overrun,
  output logic     rx_load_en
);
  logic full_set;
  logic ovr_set;

  assign full_set   = rx_ready & ~rx_full;
  assign ovr_set    = rx_ready & rx_full;
  assign rx_load_en = full_set;

  flag_two_step #(.RST_VAL(RX_FULL_RST)) full_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .stat_rd (acc.stat_rd),
    .set_evt (full_set),
    .clr_acc (acc.data_rd),
    .flag    (rx_full)
  );

  flag_two_step #(.RST_VAL(RX_OVR_RST)) ovr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .stat_rd (acc.stat_rd),
    .set_evt (ovr_set),
    .clr_acc (acc.data_rd),
    .flag    (rx_overrun)
  );

  // R6
  load_then_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load_en |=> rx_full);

  // R8
  overrun_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && rx_full) |=> rx_overrun);
endmodule

// File: rtl/uart_flag_ctrl.sv
module uart_flag_ctrl
  import uart_flag_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stat_rd,
  input  logic data_rd,
  input  logic data_wr,
  input  logic tx_en,
  input  logic brk_wr,
  input  logic tx_load,
  input  logic tx_busy,
  input  logic rx_ready,
  output logic tx_empty,
  output logic tx_done,
  output logic rx_full,
  output logic rx_overrun,
  output logic rx_load_en
);
  reg_acc_t acc;

  assign acc.stat_rd = stat_rd;
  assign acc.data_rd = data_rd;
  assign acc.data_wr = data_wr;

  tx_flag_unit tx_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc      (acc),
    .tx_en    (tx_en),
    .brk_wr   (brk_wr),
    .tx_load  (tx_load),
    .tx_busy  (tx_busy),
    .tx_empty (tx_empty),
    .tx_done  (tx_done)
  );

  rx_flag_unit rx_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc        (acc),
    .rx_ready   (rx_ready),
    .rx_full    (rx_full),
    .rx_overrun (rx_overrun),
    .rx_load_en (rx_load_en)
  );

  // R8
  no_load_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> !rx_load_en);
endmodule

// File: tb/uart_flag_ctrl_tb.sv
module uart_flag_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stat_rd = 0, data_rd = 0, data_wr = 0, tx_en = 0, brk_wr = 0;
  logic tx_load = 0, tx_busy = 0, rx_ready = 0;
  logic tx_empty, tx_done, rx_full, rx_overrun, rx_load_en;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  uart_flag_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .data_rd(data_rd),
    .data_wr(data_wr), .tx_en(tx_en), .brk_wr(brk_wr), .tx_load(tx_load),
    .tx_busy(tx_busy), .rx_ready(rx_ready), .tx_empty(tx_empty),
    .tx_done(tx_done), .rx_full(rx_full), .rx_overrun(rx_overrun),
    .rx_load_en(rx_load_en)
  );

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle_all();
    stat_rd = 0; data_rd = 0; data_wr = 0; brk_wr = 0;
    tx_load = 0; rx_ready = 0;
  endtask

  task automatic test_reset();
    check("R1 tx_empty", tx_empty, 1'b1);
    check("R1 tx_done", tx_done, 1'b1);
    check("R1 rx_full", rx_full, 1'b0);
    check("R1 rx_overrun", rx_overrun, 1'b0);
  endtask

  task automatic test_tx_empty();
    data_wr = 1; tick(); idle_all();
    check("R3 unarmed write", tx_empty, 1'b1);
    check("R5 unarmed write keeps done", tx_done, 1'b1);
    stat_rd = 1; tick(); idle_all();
    data_rd = 1; tick(); idle_all();
    data_wr = 1; tick(); idle_all();
    check("R3 armed write clears", tx_empty, 1'b0);
    check("R5 write clears done", tx_done, 1'b0);
    tx_busy = 1;
    tx_load = 1; tick(); idle_all();
    check("R2 load sets empty", tx_empty, 1'b1);
    data_wr = 1; tick(); idle_all();
    check("R10 newly set not cleared", tx_empty, 1'b1);
    check("R4 busy keeps done low", tx_done, 1'b0);
    tx_busy = 0; tick();
    check("R4 idle rise sets done", tx_done, 1'b1);
  endtask

  task automatic test_tx_done_paths();
    tx_en = 1; tick();
    check("R5 unarmed te rise", tx_done, 1'b1);
    tx_en = 0; tick();
    stat_rd = 1; tick(); idle_all();
    tx_en = 1; tick();
    check("R5 te rise clears", tx_done, 1'b0);
    check("R3 te rise keeps empty", tx_empty, 1'b1);
    tx_busy = 1; tick(); tx_busy = 0; tick();
    check("R4 done after busy pulse", tx_done, 1'b1);
    brk_wr = 1; tick(); idle_all();
    check("R5 unarmed break", tx_done, 1'b1);
    stat_rd = 1; tick(); idle_all();
    brk_wr = 1; tick(); idle_all();
    check("R5 break clears", tx_done, 1'b0);
    tx_busy = 1; tick(); tx_busy = 0; tick();
    check("R4 done restored", tx_done, 1'b1);
  endtask

  task automatic test_rx();
    rx_ready = 1; #1;
    check("R6 load enable when empty", rx_load_en, 1'b1);
    tick(); idle_all();
    check("R6 full set", rx_full, 1'b1);
    data_rd = 1; tick(); idle_all();
    check("R7 unarmed read", rx_full, 1'b1);
    rx_ready = 1; #1;
    check("R8 no load when full", rx_load_en, 1'b0);
    tick(); idle_all();
    check("R8 overrun set", rx_overrun, 1'b1);
    check("R8 full kept", rx_full, 1'b1);
    stat_rd = 1; tick(); idle_all();
    data_wr = 1; brk_wr = 1; tick(); idle_all();
    stat_rd = 1; tick(); idle_all();
    rx_ready = 1; data_rd = 1; tick(); idle_all();
    check("R7 armed read clears full", rx_full, 1'b0);
    check("R11 set wins overrun", rx_overrun, 1'b1);
    data_rd = 1; tick(); idle_all();
    check("R10 re-set overrun needs read", rx_overrun, 1'b1);
    stat_rd = 1; tick(); idle_all();
    tx_load = 1; tick(); idle_all();
    data_rd = 1; tick(); idle_all();
    check("R9 overrun cleared", rx_overrun, 1'b0);
    stat_rd = 1; tick(); idle_all();
    rx_ready = 1; tick(); idle_all();
    data_rd = 1; tick(); idle_all();
    check("R10 full set after read stays", rx_full, 1'b1);
  endtask

  initial begin
    tick(); tick();
    rst_n = 1;
    tick();
    test_reset();
    test_tx_empty();
    test_tx_done_paths();
    test_rx();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog got=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule